// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block merges three reasons to hold a processor in reset into one reset signal, presented both active-high and active-low. The reasons are: the supply being out of tolerance (a digital flag from an external comparator, brought into the clock domain by a two-flop synchronizer), a push-button request that has already been debounced, and an expiry request from a watchdog. While any reason is present, reset is driven at once. The synchronized supply flag, the button request and the expiry request reach the outputs through combinational logic, so there is no hold-off.

Once every reason has cleared, reset stays asserted for a minimum hold time. The hold time is counted in periods of a 1 ms tick-enable input. The hold count is reloaded to its full value whenever any reason reappears. A recovering supply must therefore stay good for the whole hold interval before reset lets go.

A "running" status is high whenever reset is inactive and is meant to enable a watchdog. A one-cycle release pulse marks the first cycle after reset drops, so the watchdog can start a fresh full period.

Top module: `sup_reset_pulser`

## Requirements
- R1: After the asynchronous clear is released, reset stays asserted until the synchronized supply flag has been continuously good for HOLD_MS tick periods.
- R2: A falling supply input asserts reset on the second clock edge after it falls (two synchronizer stages), with no further delay.
- R3: A push-button request asserts reset in the same cycle. After the request is released, reset stays asserted for HOLD_MS tick periods.
- R4: A watchdog expiry request, even one cycle long, asserts reset in the same cycle. Reset then stays asserted for HOLD_MS tick periods after the request clears.
- R5: Any reason to reset that appears during the hold interval reloads the hold count to HOLD_MS, so a full interval is counted again.
- R6: The hold count advances only on clock edges where tick_ms_i is 1. HOLD_MS is a parameter in the range 250 to 1000, with a default of 610.
- R7: rst_hi_o and rst_lo_n_o are always logical complements of each other.
- R8: run_ok_o is 1 exactly when reset is inactive.
- R9: release_o is 1 for exactly one cycle: the first cycle in which reset is inactive after a hold interval ends.
- R10: While rst_n is low, reset is asserted at once, the release pulse is 0 and the hold count is loaded to full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear, released synchronously |
| tick_ms_i | input | 1 | One-cycle enable once per millisecond |
| supply_ok_i | input | 1 | Asynchronous supply-in-tolerance flag, 1 = good |
| button_req_i | input | 1 | Debounced push-button reset request, active high |
| wdog_expire_i | input | 1 | Watchdog expiry request, active high |
| rst_hi_o | output | 1 | Reset, active high |
| rst_lo_n_o | output | 1 | Reset, active low |
| run_ok_o | output | 1 | Reset inactive; enables the watchdog |
| release_o | output | 1 | One-cycle pulse on the first cycle with reset inactive |

## Verification
The assertions assume that the button and watchdog requests are synchronous to clk. They assume that the supply flag is observed only through the synchronizer, and that the watchdog side never raises a request in the very cycle of a release pulse. The bench drives every input half a clock period away from the rising edge. It keeps requests and supply changes apart from release cycles. It generates the tick itself and counts the ticks that fall on cause-free edges, so the expected release edge follows arithmetically from the stimulus. Hold intervals are swept with tick periods of one, two and three cycles, with restarts caused by each kind of request, and through an asynchronous clear in the middle of a run.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int HOLD_MIN_MS = 250;
  localparam int HOLD_NOM_MS = 610;
  localparam int HOLD_MAX_MS = 1000;
  localparam int N_CAUSE     = 3;
  // Position of each reason to reset in the merged vector
  localparam int CZ_SUPPLY   = 0;
  localparam int CZ_BUTTON   = 1;
  localparam int CZ_WDOG     = 2;
endpackage

// File: rtl/srp_sync2.sv
module srp_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/srp_cause_merge.sv
module srp_cause_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] cause_i,
  output logic         any_o
);
  logic [N:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_or
    assign chain[g+1] = chain[g] | cause_i[g];
  end
  assign any_o = chain[N];
endmodule

// File: rtl/srp_hold_ctr.sv
module srp_hold_ctr #(
  parameter int HOLD_MS = 610,
  localparam int CW = $clog2(HOLD_MS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cause_i,
  output logic          hold_o,
  output logic [CW-1:0] cnt_o,
  output logic          released_o
);
  localparam logic [CW-1:0] FULL = CW'(HOLD_MS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;

  // next state
  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (cause_i) begin
      hold_d = 1'b1;
      cnt_d  = FULL;
    end else if (hold_q && tick_i) begin
      if (cnt_q == ONE) begin
        hold_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    rel_d = hold_q & ~hold_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= FULL;
      rel_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      rel_q  <= rel_d;
    end
  end

  assign hold_o     = hold_q;
  assign cnt_o      = cnt_q;
  assign released_o = rel_q;
endmodule

// File: rtl/sup_reset_pulser.sv
module sup_reset_pulser
  import srp_pkg::*;
#(
  parameter int HOLD_MS = HOLD_NOM_MS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms_i,
  input  logic supply_ok_i,
  input  logic button_req_i,
  input  logic wdog_expire_i,
  output logic rst_hi_o,
  output logic rst_lo_n_o,
  output logic run_ok_o,
  output logic release_o
);
  localparam int CW = $clog2(HOLD_MS + 1);

  logic               supply_sync;
  logic [N_CAUSE-1:0] causes;
  logic               cause_any;
  logic               hold;
  logic [CW-1:0]      hold_cnt;
  logic               released;
  logic               rst_act;

  srp_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (supply_ok_i),
    .q_o   (supply_sync)
  );

  always_comb begin
    causes            = '0;
    causes[CZ_SUPPLY] = ~supply_sync;
    causes[CZ_BUTTON] = button_req_i;
    causes[CZ_WDOG]   = wdog_expire_i;
  end

  srp_cause_merge #(.N(N_CAUSE)) u_merge (
    .cause_i (causes),
    .any_o   (cause_any)
  );

  srp_hold_ctr #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_ms_i),
    .cause_i    (cause_any),
    .hold_o     (hold),
    .cnt_o      (hold_cnt),
    .released_o (released)
  );

  // No hold-off: a present cause drives the outputs directly
  assign rst_act    = hold | cause_any;
  assign rst_hi_o   = rst_act;
  assign rst_lo_n_o = ~rst_act;
  assign run_ok_o   = ~rst_act;
  assign release_o  = released;
endmodule

// File: rtl/sup_reset_pulser_chk.sv
module sup_reset_pulser_chk #(
  parameter int HOLD_MS = 610,
  localparam int CW = $clog2(HOLD_MS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_ms_i,
  input logic          button_req_i,
  input logic          wdog_expire_i,
  input logic          rst_hi_o,
  input logic          rst_lo_n_o,
  input logic          run_ok_o,
  input logic          release_o,
  input logic          supply_sync,
  input logic [CW-1:0] hold_cnt
);
  logic any_req;
  assign any_req = button_req_i | wdog_expire_i | ~supply_sync;

  a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hi_o != rst_lo_n_o);

  a_r2_supply_now: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_sync |-> rst_hi_o);

  a_r3_button_now: assert property (@(posedge clk) disable iff (!rst_n)
    button_req_i |-> rst_hi_o);

  a_r4_wdog_now: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire_i |-> rst_hi_o);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> (hold_cnt == CW'(HOLD_MS)));

  a_r6_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_ms_i && !any_req) |=> $stable(hold_cnt));

  a_r9_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> $past(rst_hi_o));

  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o);

  a_r8_run_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_ok_o) |-> release_o);
endmodule

bind sup_reset_pulser sup_reset_pulser_chk #(.HOLD_MS(HOLD_MS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_ms_i     (tick_ms_i),
  .button_req_i  (button_req_i),
  .wdog_expire_i (wdog_expire_i),
  .rst_hi_o      (rst_hi_o),
  .rst_lo_n_o    (rst_lo_n_o),
  .run_ok_o      (run_ok_o),
  .release_o     (release_o),
  .supply_sync   (supply_sync),
  .hold_cnt      (hold_cnt)
);

// File: tb/sup_reset_pulser_tb_top.sv
module sup_reset_pulser_tb_top;
  localparam int H = 250;

  logic clk = 1'b0;
  logic rst_n, tick, sup, btn, wd;
  logic rst_hi, rst_lo_n, run_ok, rel;
  int   errors = 0;
  int   checks = 0;
  int   cyc    = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sup_reset_pulser #(.HOLD_MS(H)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_ms_i     (tick),
    .supply_ok_i   (sup),
    .button_req_i  (btn),
    .wdog_expire_i (wd),
    .rst_hi_o      (rst_hi),
    .rst_lo_n_o    (rst_lo_n),
    .run_ok_o      (run_ok),
    .release_o     (rel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Called just after a negedge, once all causes are cleared.
  // The first lat edges still see a cause; ticks on later edges count.
  task automatic hold_watch(input int lat, input int per, input string req);
    int  ticks = 0;
    bit  exp;
    for (int c = 1; c < 5000; c++) begin
      tick = ((c % per) == 0);
      @(posedge clk);
      if (c > lat && tick) ticks++;
      #1;
      exp = (ticks < H);
      check(rst_hi == exp, req, rst_hi, exp);
      check(rst_lo_n == !exp, "R7", rst_lo_n, !exp);
      check(run_ok == !exp, "R8", run_ok, !exp);
      check(rel == (ticks == H), "R9", rel, ticks == H);
      if (!exp) break;
    end
    tick = 1'b0;
    @(posedge clk); #1;
    check(rel == 1'b0, "R9", rel, 0);
    check(run_ok == 1'b1, "R8", run_ok, 1);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; sup = 1'b1; btn = 1'b0; wd = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rst_hi == 1'b1, "R10", rst_hi, 1);
    check(rst_lo_n == 1'b0, "R10", rst_lo_n, 0);
    check(run_ok == 1'b0, "R10", run_ok, 0);
    check(rel == 1'b0, "R10", rel, 0);

    // R6: no ticks, reset held indefinitely
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(rst_hi == 1'b1, "R6", rst_hi, 1);
    // R1: power-up release after H ticks (synchronizer already settled)
    hold_watch(0, 1, "R1");
    repeat (5) @(negedge clk);
    check(rel == 1'b0 && run_ok == 1'b1, "R9", rel, 0);

    // R2: supply loss through two synchronizer stages
    sup = 1'b0;
    @(posedge clk); #1;
    check(rst_hi == 1'b0, "R2", rst_hi, 0);
    @(posedge clk); #1;
    check(rst_hi == 1'b1, "R2", rst_hi, 1);
    repeat (10) @(negedge clk);
    sup = 1'b1;
    hold_watch(2, 3, "R2");

    // R3: button, immediate and held H ticks after release
    btn = 1'b1; #1;
    check(rst_hi == 1'b1, "R3", rst_hi, 1);
    repeat (20) @(negedge clk);
    btn = 1'b0;
    hold_watch(0, 1, "R3");

    // R4: single-cycle watchdog expiry
    wd = 1'b1; #1;
    check(rst_hi == 1'b1, "R4", rst_hi, 1);
    @(negedge clk);
    wd = 1'b0;
    hold_watch(0, 2, "R4");

    // R5: restart by watchdog pulse during hold
    btn = 1'b1;
    @(negedge clk);
    btn = 1'b0; tick = 1'b1;
    repeat (100) @(negedge clk);
    check(rst_hi == 1'b1, "R5", rst_hi, 1);
    wd = 1'b1; tick = 1'b0;
    @(negedge clk);
    wd = 1'b0;
    hold_watch(0, 1, "R5");

    // R5: restart by a one-cycle supply glitch during hold
    btn = 1'b1;
    @(negedge clk);
    btn = 1'b0; tick = 1'b1;
    repeat (50) @(negedge clk);
    tick = 1'b0; sup = 1'b0;
    @(negedge clk);
    sup = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(rst_hi == 1'b1, "R5", rst_hi, 1);
    hold_watch(1, 1, "R5");

    // R10: asynchronous clear mid-run, then R1 with synchronizer refill
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b0; #1;
    check(rst_hi == 1'b1, "R10", rst_hi, 1);
    check(run_ok == 1'b0, "R10", run_ok, 0);
    @(negedge clk);
    rst_n = 1'b1;
    hold_watch(2, 1, "R1");

    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end
endmodule